// File: doc/BRIEF.md
# Left-Justified Load/Store Data Formatter

This block sits between a 64-bit memory data bus and a 64-bit accumulator whose bits are counted from the most significant end, so that accumulator bit 0 is the MSB. Memory data arrives right-justified on the bus. On a load, the block moves the item to the top of the accumulator word and clears every lower bit. Narrow data therefore takes part in signed arithmetic as a fraction of full scale.

Bytes are taken as unsigned. They are placed one position below the sign bit, so they always read as non-negative signed values. In stereo mode the accumulator is treated as two 32-bit lanes. The item is split into an upper half and a lower half, and each half is left-justified in its own lane. A store applies the exact inverse transform, giving right-justified memory data with zero upper bits.

The path is combinational. A single output register captures the result whenever the valid input is high.

Top module: `msb_fmt`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0 and `dout` is all zeros.
- R2: `out_valid` equals `in_valid` of the previous cycle. While `in_valid` is 0, `dout` keeps its last value and the data, size, mode and direction inputs have no effect on it.
- R3: A scalar byte load (`dir`=0, `stereo`=0, `size`=00) gives `dout[63]`=0, `dout[62:55]`=`din[7:0]` and `dout[54:0]`=0.
- R4: A scalar 16-bit load (`size`=01) gives `din[15:0]` in `dout[63:48]` with zeros below it. A scalar 32-bit load (`size`=10) gives `din[31:0]` in `dout[63:32]` with zeros below it. No sign or zero bit is added above the data.
- R5: A scalar 64-bit load (`size`=11) passes `din` through unchanged.
- R6: A stereo load (`stereo`=1) of width W = 8, 16 or 32 places the upper half `din[W-1:W/2]` at `dout[63:64-W/2]` and the lower half `din[W/2-1:0]` at `dout[31:32-W/2]`. All other bits are 0. In the 32-bit case, `din[31:16]` goes to `dout[63:48]` and `din[15:0]` goes to `dout[31:16]`.
- R7: A stereo 64-bit load passes `din` through unchanged.
- R8: A scalar store (`dir`=1) returns the accumulator field that a load of the same size fills, right-justified, with zeros above it. For bytes this field is `din[62:55]`. Accumulator bits outside the field have no effect on the result.
- R9: A stereo store of width W returns {`din[63:64-W/2]`, `din[31:32-W/2]`} right-justified, with zeros above it. Accumulator bits outside the two lane fields have no effect on the result.
- R10: For every size and mode, storing the result of a load returns the original low W bits of the loaded data, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; updates the output register |
| dir | input | 1 | 0 = load (memory to accumulator), 1 = store (accumulator to memory) |
| size | input | 2 | 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| stereo | input | 1 | 0 = scalar, 1 = two-lane stereo layout |
| din | input | 64 | Right-justified memory data (load) or accumulator word (store) |
| out_valid | output | 1 | Registered result valid |
| dout | output | 64 | Registered formatted word |

## Verification
The hardest case to reach is a store that must ignore accumulator bits outside its field. This includes the sign bit in a byte store and the bits between the two lanes in a stereo store. Directed and random full-width accumulator words put ones in exactly those places, so a wrong slice or a missing mask shows up in the result. Every random load is also fed back as a store, which checks the round trip for each size and mode. Idle cycles with changing inputs check that the output register holds its value.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } fmt_size_e;

  localparam int NUM_SIZES = 4;
  localparam int MIN_ITEM_W = 8;
endpackage

// File: rtl/fmt_load.sv
module fmt_load import fmt_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] mem_d,
  input  fmt_size_e         size,
  input  logic              stereo,
  output logic [DATA_W-1:0] acc_d
);
  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] scal [NUM_SIZES];
  logic [DATA_W-1:0] ster [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int W  = MIN_ITEM_W << k;
    localparam int HW = W / 2;
    // scalar: left-justify; bytes sit one bit below the sign
    if (k == 0) begin : g_byte
      assign scal[k] = {1'b0, mem_d[W-1:0], {(DATA_W-W-1){1'b0}}};
    end else if (W == DATA_W) begin : g_full
      assign scal[k] = mem_d;
    end else begin : g_part
      assign scal[k] = {mem_d[W-1:0], {(DATA_W-W){1'b0}}};
    end
    // stereo: each half left-justified in its own lane
    if (HW == LANE_W) begin : g_sfull
      assign ster[k] = mem_d;
    end else begin : g_spart
      assign ster[k] = {mem_d[W-1:HW], {(LANE_W-HW){1'b0}},
                        mem_d[HW-1:0], {(LANE_W-HW){1'b0}}};
    end
  end

  always_comb begin
    acc_d = stereo ? ster[size] : scal[size];
  end
endmodule

// File: rtl/fmt_store.sv
module fmt_store import fmt_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] acc_d,
  input  fmt_size_e         size,
  input  logic              stereo,
  output logic [DATA_W-1:0] mem_d
);
  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] scal [NUM_SIZES];
  logic [DATA_W-1:0] ster [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int W  = MIN_ITEM_W << k;
    localparam int HW = W / 2;
    if (k == 0) begin : g_byte
      assign scal[k] = {{(DATA_W-W){1'b0}}, acc_d[DATA_W-2 -: W]};
    end else if (W == DATA_W) begin : g_full
      assign scal[k] = acc_d;
    end else begin : g_part
      assign scal[k] = {{(DATA_W-W){1'b0}}, acc_d[DATA_W-1 -: W]};
    end
    if (HW == LANE_W) begin : g_sfull
      assign ster[k] = acc_d;
    end else begin : g_spart
      assign ster[k] = {{(DATA_W-W){1'b0}},
                        acc_d[DATA_W-1 -: HW], acc_d[LANE_W-1 -: HW]};
    end
  end

  always_comb begin
    mem_d = stereo ? ster[size] : scal[size];
  end
endmodule

// File: rtl/fmt_out_reg.sv
module fmt_out_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic              q_valid,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= en;
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/msb_fmt.sv
module msb_fmt import fmt_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              dir,
  input  logic [1:0]        size,
  input  logic              stereo,
  input  logic [DATA_W-1:0] din,
  output logic              out_valid,
  output logic [DATA_W-1:0] dout
);
  fmt_size_e         sz;
  logic [DATA_W-1:0] ld_res;
  logic [DATA_W-1:0] st_res;
  logic [DATA_W-1:0] sel_res;

  assign sz = fmt_size_e'(size);

  fmt_load #(.DATA_W(DATA_W)) u_load (
    .mem_d  (din),
    .size   (sz),
    .stereo (stereo),
    .acc_d  (ld_res)
  );

  fmt_store #(.DATA_W(DATA_W)) u_store (
    .acc_d  (din),
    .size   (sz),
    .stereo (stereo),
    .mem_d  (st_res)
  );

  assign sel_res = dir ? st_res : ld_res;

  fmt_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .en      (in_valid),
    .d       (sel_res),
    .q_valid (out_valid),
    .q       (dout)
  );
endmodule

// File: rtl/msb_fmt_chk.sv
module msb_fmt_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              dir,
  input logic [1:0]        size,
  input logic              stereo,
  input logic [DATA_W-1:0] din,
  input logic              out_valid,
  input logic [DATA_W-1:0] dout
);
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dout));

  assert_byte_positive_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dir && !stereo && size == 2'b00)
      |=> (dout[DATA_W-1] == 1'b0 && dout[DATA_W-10:0] == '0));

  assert_half_lowzero_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dir && !stereo && size == 2'b01)
      |=> (dout[DATA_W-17:0] == '0));

  assert_full_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dir && !stereo && size == 2'b11)
      |=> (dout == $past(din)));

  assert_byte_store_hi_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir && !stereo && size == 2'b00)
      |=> (dout[DATA_W-1:8] == '0));
endmodule

bind msb_fmt msb_fmt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .dir       (dir),
  .size      (size),
  .stereo    (stereo),
  .din       (din),
  .out_valid (out_valid),
  .dout      (dout)
);

// File: tb/sim_msb_fmt.sv
module sim_msb_fmt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        dir = 1'b0;
  logic [1:0]  size = 2'b00;
  logic        stereo = 1'b0;
  logic [63:0] din = '0;
  logic        out_valid;
  logic [63:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  msb_fmt u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dir(dir), .size(size),
    .stereo(stereo), .din(din), .out_valid(out_valid), .dout(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] fmask(input int w);
    if (w >= 64) return '1;
    return (64'h1 << w) - 64'h1;
  endfunction

  function automatic logic [63:0] exp_load(input logic [1:0] sz, input logic st,
                                           input logic [63:0] d);
    int w = 8 << sz;
    int hw = w / 2;
    logic [63:0] hi, lo;
    if (st) begin
      hi = (d >> hw) & fmask(hw);
      lo = d & fmask(hw);
      return (hi << (64 - hw)) | (lo << (32 - hw));
    end
    if (sz == 2'b00) return (d & 64'hFF) << 55;
    return (d & fmask(w)) << (64 - w);
  endfunction

  function automatic logic [63:0] exp_store(input logic [1:0] sz, input logic st,
                                            input logic [63:0] a);
    int w = 8 << sz;
    int hw = w / 2;
    logic [63:0] hi, lo;
    if (st) begin
      hi = (a >> (64 - hw)) & fmask(hw);
      lo = (a >> (32 - hw)) & fmask(hw);
      return (hi << hw) | lo;
    end
    if (sz == 2'b00) return (a >> 55) & 64'hFF;
    return (a >> (64 - w)) & fmask(w);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply one request, sample one cycle later at the falling edge
  task automatic run(input logic d_dir, input logic [1:0] sz, input logic st,
                     input logic [63:0] d, output logic [63:0] res);
    @(negedge clk);
    in_valid = 1'b1; dir = d_dir; size = sz; stereo = st; din = d;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 out_valid", {63'd0, out_valid}, 64'd1);
    res = dout;
  endtask

  function automatic string req_of(input logic d_dir, input logic [1:0] sz, input logic st);
    if (d_dir) return st ? "R9" : "R8";
    if (st) return (sz == 2'b11) ? "R7" : "R6";
    if (sz == 2'b00) return "R3";
    if (sz == 2'b11) return "R5";
    return "R4";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] r, r2, held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 dout in reset", dout, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 dout after reset", dout, 64'd0);
    check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);

    // directed corners
    run(1'b0, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, r);
    check("R3 byte FF", r, 64'h7F80_0000_0000_0000);
    run(1'b0, 2'b01, 1'b0, 64'h1234_5678_9ABC_8001, r);
    check("R4 half 8001", r, 64'h8001_0000_0000_0000);
    run(1'b0, 2'b10, 1'b0, 64'hFFFF_FFFF_8000_0001, r);
    check("R4 word", r, 64'h8000_0001_0000_0000);
    run(1'b0, 2'b11, 1'b0, 64'hDEAD_BEEF_0123_4567, r);
    check("R5 full", r, 64'hDEAD_BEEF_0123_4567);
    run(1'b0, 2'b10, 1'b1, 64'h0000_0000_AAAA_5555, r);
    check("R6 stereo 32", r, 64'hAAAA_0000_5555_0000);
    run(1'b0, 2'b00, 1'b1, 64'h0000_0000_0000_00C3, r);
    check("R6 stereo 8", r, 64'hC000_0000_3000_0000);
    run(1'b0, 2'b11, 1'b1, 64'h0F0F_1234_F0F0_5678, r);
    check("R7 stereo 64", r, 64'h0F0F_1234_F0F0_5678);
    run(1'b1, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, r);
    check("R8 byte store ignores sign", r, 64'h0000_0000_0000_00FF);
    run(1'b1, 2'b00, 1'b0, 64'h8000_0000_0000_0000, r);
    check("R8 byte store sign only", r, 64'd0);
    run(1'b1, 2'b10, 1'b1, 64'hAAAA_FFFF_5555_FFFF, r);
    check("R9 stereo 32 store", r, 64'h0000_0000_AAAA_5555);

    // hold while idle, inputs toggling
    held = dout;
    @(negedge clk);
    dir = 1'b0; size = 2'b11; stereo = 1'b0; din = 64'h1111_2222_3333_4444;
    @(negedge clk);
    check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
    check("R2 idle hold", dout, held);

    // random mix with round trip
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz = 2'($urandom_range(0, 3));
      logic st = 1'($urandom_range(0, 1));
      logic [63:0] d = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) begin
        run(1'b0, sz, st, d, r);
        check(req_of(1'b0, sz, st), r, exp_load(sz, st, d));
        run(1'b1, sz, st, r, r2);
        check("R10 round trip", r2, d & fmask(8 << sz));
      end else begin
        run(1'b1, sz, st, d, r);
        check(req_of(1'b1, sz, st), r, exp_store(sz, st, d));
      end
      if ((i % 50) == 0) begin
        held = dout;
        @(negedge clk);
        din = ~din;
        @(negedge clk);
        check("R2 idle hold random", dout, held);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule